// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

This block turns queued packet bytes into a bit-serial HDLC line stream. A byte-wide write port fills a small internal queue. Each entry carries a ninth bit that marks the final byte of a packet. The framer wraps each packet in opening and closing 7Eh flags. It appends a 16-bit frame check sequence and applies zero insertion to the packet body. Between packets it keeps the line busy with a fill byte.

The output advances by one bit only on cycles where the bit-enable strobe is high, so a gapped overhead clock can drive the block directly. Static configuration inputs give test and interworking options: drop the check sequence, corrupt it on purpose by inverting all of its bits, turn off zero insertion, choose idle or flag fill, and invert the whole line stream.

A rising edge on the flush input empties the queue and sends one abort byte. If the queue runs dry in the middle of a packet, the framer aborts the packet and raises a sticky underrun flag.

Top module: `hdlc_tx_framer`

## Requirements
- R1: A packet goes out as an opening flag 7Eh, then the packet bytes in write order, each sent least significant bit first, then the check sequence, then a closing flag 7Eh. Every byte on the line is sent LSB first.
- R2: When `cfg_fcs_off` is 0, the check sequence is CRC-16-CCITT (polynomial x^16+x^12+x^5+1, bit-reflected, seed FFFFh) over the data bits. The register is complemented and sent LSB first. When `cfg_fcs_off` is 1, the closing flag follows the last data byte directly.
- R3: When `cfg_fcs_inv` is 1, all 16 bits of the check sequence are inverted compared with R2. With `cfg_fcs_off` at 1, `cfg_fcs_inv` has no effect.
- R4: When `cfg_stuff_off` is 0, a 0 is inserted after every run of five consecutive 1s among the data and check-sequence bits, including a run that ends on the last check bit. Flags, fill bytes and the abort byte are never stuffed. When `cfg_stuff_off` is 1, no 0 is inserted.
- R5: Between packets the fill byte is 7Eh when `cfg_fill_idle` is 0 and FFh when it is 1.
- R6: When `cfg_out_inv` is 1, every line bit is inverted, including flags, fill, abort and check bits.
- R7: A 0-to-1 transition of `flush_in` empties the queue. It drops any write in the same cycle and clears `underrun`. The line then carries one abort byte FEh (a 0, then seven 1s) followed by fill bytes.
- R8: A packet starts only at a byte boundary of fill, closing flag or abort. It also needs at least two queued bytes, or one queued byte that is marked as the last.
- R9: If a non-final data byte finishes and the queue is empty, the framer sends the abort byte FEh, then returns to fill. It sets `underrun`, which stays at 1 until the next flush edge.
- R10: The queue holds FIFO_DEPTH (16) entries. `full` is 1 exactly when all entries are used. A write while `full` is 1 is dropped.
- R11: `tx_bit` changes only on a clock edge at which `bit_en` is 1. After reset, `tx_bit` is 1 and `full` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Line bit strobe; one output bit per high cycle |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Packet byte to queue |
| wr_last | input | 1 | Marks the written byte as the last of its packet |
| full | output | 1 | Queue has no free entry |
| cfg_fcs_off | input | 1 | Omit the check sequence |
| cfg_fcs_inv | input | 1 | Invert all check sequence bits |
| cfg_stuff_off | input | 1 | Disable zero insertion |
| cfg_fill_idle | input | 1 | Fill with FFh instead of 7Eh |
| cfg_out_inv | input | 1 | Invert the whole line stream |
| flush_in | input | 1 | Rising edge flushes the queue and sends an abort |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | Sticky flag: a packet was aborted for lack of data |

## Verification
The bench covers several corner cases.
- Runs of 1s in data that cross byte boundaries and reach into the check sequence. A framer that resets its run count per byte or per field would leave six 1s on the line and fake a flag.
- A one-byte packet, and a lone non-final byte that must wait. Starting too early would put a half-packet on the line; waiting for two bytes would hang a short packet.
- A flush that lands on a queued byte. A design that keeps the byte would show it inside the next frame.
- The inverted check with the check sequence turned off, where a leaking inversion would add bits before the closing flag.
- A 16-entry fill with a 17th write while the line is stalled. Overwriting the head would corrupt the long frame that follows.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   localparam int BYTE_W = 8;
   localparam int FCS_W  = 16;

   localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
   localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;
   localparam logic [BYTE_W-1:0] ABORT_BYTE = 8'hFE;

   // Bit-reflected x^16+x^12+x^5+1 and its seed
   localparam logic [FCS_W-1:0] FCS_POLY_REFL = 16'h8408;
   localparam logic [FCS_W-1:0] FCS_SEED      = 16'hFFFF;

   typedef enum logic [2:0] {
      ST_FILL,
      ST_OPEN,
      ST_DATA,
      ST_FCS,
      ST_CLOSE,
      ST_ABORT
   } tx_state_e;

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
   parameter int DW    = 9,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("hdlc_tx_fifo: DEPTH must be a power of two and at least 2");
      end
      if (DW < 2) begin : g_bad_width
         $error("hdlc_tx_fifo: DW must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic          do_wr, do_rd;

   assign full  = (count == CW'(DEPTH));
   assign do_wr = wr_en && !full && !clear;
   assign do_rd = rd_en && (count != '0) && !clear;
   assign head  = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (do_wr) mem_q[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else if (clear) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + AW'(1);
         if (do_rd) rp_q <= rp_q + AW'(1);
         count <= count + CW'(do_wr) - CW'(do_rd);
      end
   end

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
   import hdlc_tx_pkg::*;
#(
   parameter int            W    = FCS_W,
   parameter logic [W-1:0]  POLY = FCS_POLY_REFL,
   parameter logic [W-1:0]  SEED = FCS_SEED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed_en,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] crc
);

   generate
      if (W < 8) begin : g_bad_w
         $error("hdlc_tx_fcs: W must be at least 8");
      end
   endgenerate

   // LSB-first serial update of a bit-reflected CRC
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        crc <= SEED;
      else if (seed_en)  crc <= SEED;
      else if (shift_en) crc <= (crc >> 1) ^ ((crc[0] ^ din) ? POLY : '0);
   end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int STUFF_RUN  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_last,
   output logic              full,
   input  logic              cfg_fcs_off,
   input  logic              cfg_fcs_inv,
   input  logic              cfg_stuff_off,
   input  logic              cfg_fill_idle,
   input  logic              cfg_out_inv,
   input  logic              flush_in,
   output logic              tx_bit,
   output logic              underrun
);

   localparam int CW  = $clog2(FIFO_DEPTH + 1);
   localparam int EW  = BYTE_W + 1;
   localparam int IW  = $clog2(FCS_W);
   localparam int OW  = $clog2(STUFF_RUN + 2);
   localparam logic [IW-1:0] BYTE_END = IW'(BYTE_W - 1);
   localparam logic [IW-1:0] FCS_END  = IW'(FCS_W - 1);
   localparam logic [OW-1:0] RUN_MAX  = OW'(STUFF_RUN + 1);

   generate
      if (STUFF_RUN < 1 || STUFF_RUN >= BYTE_W) begin : g_bad_run
         $error("hdlc_tx_framer: STUFF_RUN must lie in 1..7");
      end
   endgenerate

   tx_state_e         st_q;
   logic [IW-1:0]     idx_q;
   logic [OW-1:0]     ones_q;
   logic [BYTE_W-1:0] cur_q;
   logic              cur_last_q;
   logic              flush_q;
   logic              tx_q;
   logic              unr_q;

   logic [CW-1:0]     fifo_cnt;
   logic [EW-1:0]     head;
   logic              pop;
   logic [FCS_W-1:0]  crc_val;
   logic [FCS_W-1:0]  fcs_word;
   logic [BYTE_W-1:0] fill_byte;
   logic              flush_rise, ready, fifo_empty;
   logic              stuffed, ins_zero, advance, last_bit, raw_bit;

   assign flush_rise = flush_in && !flush_q;
   assign fifo_empty = (fifo_cnt == '0);
   assign ready      = (fifo_cnt >= CW'(2)) || (!fifo_empty && head[BYTE_W]);
   assign fill_byte  = cfg_fill_idle ? IDLE_BYTE : FLAG_BYTE;
   assign fcs_word   = cfg_fcs_inv ? crc_val : ~crc_val;
   assign stuffed    = (st_q == ST_DATA) || (st_q == ST_FCS);
   assign ins_zero   = !cfg_stuff_off && (ones_q == OW'(STUFF_RUN));
   assign advance    = bit_en && !ins_zero && !flush_rise;
   assign last_bit   = (idx_q == ((st_q == ST_FCS) ? FCS_END : BYTE_END));
   assign pop        = advance && last_bit &&
                       ((st_q == ST_OPEN) ||
                        (st_q == ST_DATA && !cur_last_q && !fifo_empty));

   always_comb begin
      unique case (st_q)
         ST_OPEN, ST_CLOSE: raw_bit = FLAG_BYTE[idx_q[2:0]];
         ST_DATA:           raw_bit = cur_q[idx_q[2:0]];
         ST_FCS:            raw_bit = fcs_word[idx_q];
         ST_ABORT:          raw_bit = ABORT_BYTE[idx_q[2:0]];
         default:           raw_bit = fill_byte[idx_q[2:0]];
      endcase
   end

   hdlc_tx_fifo #(.DW(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (flush_rise),
      .wr_en   (wr_en),
      .wr_data ({wr_last, wr_data}),
      .rd_en   (pop),
      .head    (head),
      .count   (fifo_cnt),
      .full    (full)
   );

   hdlc_tx_fcs u_fcs (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_en  (advance && st_q == ST_OPEN),
      .shift_en (advance && st_q == ST_DATA),
      .din      (cur_q[idx_q[2:0]]),
      .crc      (crc_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_FILL;
         idx_q      <= '0;
         ones_q     <= '0;
         cur_q      <= '0;
         cur_last_q <= 1'b0;
         flush_q    <= 1'b0;
         tx_q       <= 1'b1;
         unr_q      <= 1'b0;
      end else begin
         flush_q <= flush_in;
         if (flush_rise) begin
            st_q   <= ST_ABORT;
            ones_q <= '0;
            unr_q  <= 1'b0;
            idx_q  <= bit_en ? IW'(1) : '0;
            if (bit_en) tx_q <= ABORT_BYTE[0] ^ cfg_out_inv;
         end else if (bit_en) begin
            tx_q <= (ins_zero ? 1'b0 : raw_bit) ^ cfg_out_inv;
            if (ins_zero) begin
               ones_q <= '0;
            end else begin
               if (stuffed && raw_bit) ones_q <= (ones_q == RUN_MAX) ? RUN_MAX : ones_q + OW'(1);
               else                    ones_q <= '0;
               if (!last_bit) begin
                  idx_q <= idx_q + IW'(1);
               end else begin
                  idx_q <= '0;
                  unique case (st_q)
                     ST_OPEN: begin
                        st_q       <= ST_DATA;
                        cur_q      <= head[BYTE_W-1:0];
                        cur_last_q <= head[BYTE_W];
                     end
                     ST_DATA: begin
                        if (cur_last_q) begin
                           st_q <= cfg_fcs_off ? ST_CLOSE : ST_FCS;
                        end else if (fifo_empty) begin
                           st_q  <= ST_ABORT;
                           unr_q <= 1'b1;
                        end else begin
                           cur_q      <= head[BYTE_W-1:0];
                           cur_last_q <= head[BYTE_W];
                        end
                     end
                     ST_FCS:  st_q <= ST_CLOSE;
                     default: st_q <= ready ? ST_OPEN : ST_FILL;
                  endcase
               end
            end
         end
      end
   end

   assign tx_bit   = tx_q;
   assign underrun = unr_q;

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_en,
   input logic          tx_bit,
   input logic          wr_en,
   input logic          full,
   input logic          flush_in,
   input logic          underrun,
   input logic [CW-1:0] fifo_cnt
);

   logic flush_prev;
   logic edge_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_prev <= 1'b0;
      else        flush_prev <= flush_in;
   end
   assign edge_seen = flush_in && !flush_prev;

   // R11: the line holds whenever the strobe is low
   a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   // R10: a stalled, full queue stays full and never grows past its depth
   a_r10_full_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !bit_en && !edge_seen) |=> (full && fifo_cnt == CW'(DEPTH)));

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));

   // R9: underrun is sticky until a flush edge
   a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !edge_seen) |=> underrun);

   // R7: a flush edge empties the queue and clears underrun
   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> (fifo_cnt == '0 && !underrun));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .tx_bit   (tx_bit),
   .wr_en    (wr_en),
   .full     (full),
   .flush_in (flush_in),
   .underrun (underrun),
   .fifo_cnt (fifo_cnt)
);

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       wr_last;
   logic       full;
   logic       cfg_fcs_off, cfg_fcs_inv, cfg_stuff_off, cfg_fill_idle, cfg_out_inv;
   logic       flush_in;
   logic       tx_bit;
   logic       underrun;

   always #5 clk = ~clk;

   hdlc_tx_framer dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .full(full),
      .cfg_fcs_off(cfg_fcs_off), .cfg_fcs_inv(cfg_fcs_inv),
      .cfg_stuff_off(cfg_stuff_off), .cfg_fill_idle(cfg_fill_idle),
      .cfg_out_inv(cfg_out_inv), .flush_in(flush_in),
      .tx_bit(tx_bit), .underrun(underrun)
   );

   typedef struct {
      logic [0:399] bits;
      int           len;
      string        tag;
   } exp_t;

   exp_t     sb[$];
   exp_t     bld;
   int       bld_ones;
   logic [7:0] pkt [16];
   logic     log_q [512];
   int       nlog = 0;
   int       checks = 0;
   int       errors = 0;
   logic     run_en = 1'b0;
   logic     done = 1'b0;

   // ---------------- expected-pattern builders ----------------
   function automatic void put_raw(logic b);
      bld.bits[bld.len] = b;
      bld.len++;
   endfunction

   function automatic void put_byte_raw(logic [7:0] b);
      for (int i = 0; i < 8; i++) put_raw(b[i]);
   endfunction

   function automatic void put_stuffed(logic b);
      put_raw(b);
      if (b) bld_ones++;
      else   bld_ones = 0;
      if (!cfg_stuff_off && bld_ones == 5) begin
         put_raw(1'b0);
         bld_ones = 0;
      end
   endfunction

   function automatic void finish_push(string tag);
      if (cfg_out_inv)
         for (int i = 0; i < bld.len; i++) bld.bits[i] = ~bld.bits[i];
      bld.tag = tag;
      sb.push_back(bld);
   endfunction

   function automatic void push_frame(int n, string tag);
      logic [15:0] c;
      logic [15:0] f;
      logic        fb;
      bld.len  = 0;
      bld_ones = 0;
      c        = 16'hFFFF;
      put_byte_raw(8'h7E);
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++) begin
            put_stuffed(pkt[k][i]);
            fb = c[0] ^ pkt[k][i];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      if (!cfg_fcs_off) begin
         f = ~c;
         if (cfg_fcs_inv) f = ~f;
         for (int i = 0; i < 16; i++) put_stuffed(f[i]);
      end
      put_byte_raw(8'h7E);
      finish_push(tag);
   endfunction

   function automatic void push_fill(string tag);
      bld.len = 0;
      put_byte_raw(cfg_fill_idle ? 8'hFF : 8'h7E);
      put_byte_raw(cfg_fill_idle ? 8'hFF : 8'h7E);
      finish_push(tag);
   endfunction

   function automatic void push_abort(string tag);
      bld.len = 0;
      put_byte_raw(8'hFE);
      put_byte_raw(cfg_fill_idle ? 8'hFF : 8'h7E);
      finish_push(tag);
   endfunction

   function automatic void push_underrun(string tag);
      bld.len = 0;
      put_byte_raw(8'h7E);
      put_byte_raw(pkt[0]);
      put_byte_raw(pkt[1]);
      put_byte_raw(8'hFE);
      put_byte_raw(8'h7E);
      finish_push(tag);
   endfunction

   // ---------------- driver tasks ----------------
   task automatic wr_byte(input logic [7:0] b, input logic last);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = b;
      wr_last = last;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic send_pkt(input int n);
      for (int k = 0; k < n; k++) wr_byte(pkt[k], k == n - 1);
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      flush_in = 1'b1;
      repeat (3) @(negedge clk);
      flush_in = 1'b0;
   endtask

   task automatic wait_sb();
      int t;
      t = 0;
      while (sb.size() > 0 && t < 8000) begin
         @(negedge clk);
         t++;
      end
      if (sb.size() > 0) begin
         checks++;
         errors++;
         $display("FAIL %s: actual=pattern not seen after %0d line bits, expected=%0d-bit pattern",
                  sb[0].tag, nlog, sb[0].len);
         sb.delete();
      end
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // ---------------- strobe generator: two of every three cycles ----------------
   initial begin : strobe_gen
      int ph;
      ph     = 0;
      bit_en = 1'b0;
      forever begin
         @(negedge clk);
         ph     = (ph + 1) % 3;
         bit_en = run_en && (ph != 0);
      end
   end

   // ---------------- monitor / scoreboard ----------------
   initial begin : monitor
      logic en_s;
      bit   ok;
      int   len;
      forever begin
         @(posedge clk);
         en_s = bit_en && rst_n;
         @(negedge clk);
         if (en_s) begin
            log_q[nlog % 512] = tx_bit;
            nlog++;
            if (sb.size() > 0 && nlog >= sb[0].len) begin
               len = sb[0].len;
               ok  = 1'b1;
               for (int i = 0; i < len; i++)
                  if (log_q[(nlog - len + i) % 512] !== sb[0].bits[i]) ok = 1'b0;
               if (ok) begin
                  checks++;
                  void'(sb.pop_front());
               end
            end
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=run still busy expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin : stim
      logic held;
      bit   periodic;
      int   ones8;
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_last = 1'b0; flush_in = 1'b0;
      cfg_fcs_off = 1'b0; cfg_fcs_inv = 1'b0; cfg_stuff_off = 1'b0;
      cfg_fill_idle = 1'b0; cfg_out_inv = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11 / R10 / R9 reset values
      chk("R11 reset tx_bit", tx_bit, 1'b1);
      chk("R10 reset full", full, 1'b0);
      chk("R9 reset underrun", underrun, 1'b0);
      run_en = 1'b1;

      // R5 flag fill
      push_fill("R5 flag fill");
      wait_sb();

      // R1 R2 basic frame
      pkt[0] = 8'h12; pkt[1] = 8'h34; pkt[2] = 8'h56;
      push_frame(3, "R1 R2 basic frame");
      send_pkt(3);
      wait_sb();

      // R4 runs of ones across bytes and into the check sequence
      pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h3E;
      push_frame(3, "R4 zero insertion");
      send_pkt(3);
      wait_sb();

      // R3 inverted check sequence
      cfg_fcs_inv = 1'b1;
      pkt[0] = 8'hA5; pkt[1] = 8'h0F;
      push_frame(2, "R3 inverted check");
      send_pkt(2);
      wait_sb();

      // R2 R3 check omitted, inversion ignored; R8 single-byte packet
      cfg_fcs_off = 1'b1;
      pkt[0] = 8'h81;
      push_frame(1, "R3 R8 no check, one byte");
      send_pkt(1);
      wait_sb();
      cfg_fcs_off = 1'b0; cfg_fcs_inv = 1'b0;

      // R4 stuffing disabled
      cfg_stuff_off = 1'b1;
      pkt[0] = 8'hFF; pkt[1] = 8'hFF;
      push_frame(2, "R4 stuffing off");
      send_pkt(2);
      wait_sb();
      cfg_stuff_off = 1'b0;

      // R5 idle fill, then a frame between idle bytes
      cfg_fill_idle = 1'b1;
      push_fill("R5 idle fill");
      wait_sb();
      pkt[0] = 8'h7E; pkt[1] = 8'h11;
      push_frame(2, "R5 frame in idle");
      send_pkt(2);
      wait_sb();
      cfg_fill_idle = 1'b0;

      // R6 whole-stream inversion
      cfg_out_inv = 1'b1;
      push_fill("R6 inverted fill");
      wait_sb();
      pkt[0] = 8'h3C; pkt[1] = 8'hF0; pkt[2] = 8'h1F;
      push_frame(3, "R6 inverted frame");
      send_pkt(3);
      wait_sb();
      cfg_out_inv = 1'b0;
      push_fill("R6 back to plain fill");
      wait_sb();

      // R8 a lone non-final byte must not start a packet
      wr_byte(8'h55, 1'b0);
      repeat (150) @(negedge clk);
      periodic = 1'b1;
      for (int i = 0; i < 16; i++)
         if (log_q[(nlog - 1 - i) % 512] !== log_q[(nlog - 9 - i) % 512]) periodic = 1'b0;
      ones8 = 0;
      for (int i = 0; i < 8; i++) ones8 += int'(log_q[(nlog - 1 - i) % 512]);
      chk("R8 hold-off periodic fill", periodic, 1'b1);
      chk("R8 hold-off six ones per byte", ones8 == 6, 1'b1);
      pkt[0] = 8'h55; pkt[1] = 8'hAA;
      push_frame(2, "R8 start once second byte queued");
      wr_byte(8'hAA, 1'b1);
      wait_sb();

      // R7 flush drops a queued byte and sends an abort
      wr_byte(8'h99, 1'b0);
      push_abort("R7 abort after flush");
      pulse_flush();
      wait_sb();
      pkt[0] = 8'h22; pkt[1] = 8'h44;
      push_frame(2, "R7 queue emptied by flush");
      send_pkt(2);
      wait_sb();

      // R9 underrun mid-packet
      pkt[0] = 8'h55; pkt[1] = 8'hAA;
      push_underrun("R9 underrun abort");
      wr_byte(8'h55, 1'b0);
      wr_byte(8'hAA, 1'b0);
      wait_sb();
      chk("R9 underrun set", underrun, 1'b1);
      repeat (100) @(negedge clk);
      chk("R9 underrun sticky", underrun, 1'b1);
      push_abort("R7 abort clears underrun");
      pulse_flush();
      chk("R7 underrun cleared", underrun, 1'b0);
      wait_sb();

      // R10 full queue with the line stalled; R11 no strobe, no change
      run_en = 1'b0;
      repeat (4) @(negedge clk);
      held = tx_bit;
      for (int k = 0; k < 16; k++) pkt[k] = 8'(k * 37 + 5);
      send_pkt(16);
      chk("R10 full after 16 writes", full, 1'b1);
      wr_byte(8'h5A, 1'b1);
      chk("R10 still full after dropped write", full, 1'b1);
      chk("R11 line held without strobe", tx_bit, held);
      push_frame(16, "R10 sixteen-byte frame intact");
      run_en = 1'b1;
      wait_sb();
      chk("R10 full cleared after drain", full, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule